// File: doc/BRIEF.md
# Two-Trit Ternary Magnitude Comparator

This block compares two unsigned base-3 numbers of two digits each and reports, as three separate ternary results, whether the first operand equals the second, is smaller than it, or is larger than it. Each digit (trit) arrives on a 2-bit code. The block turns every trit into three one-hot unary literals. It then forms the three results as sums of products over those literals. A true result is driven as ternary level 2 and a false result as level 0.

The comparator is purely combinational and has no clock. A result is valid as soon as the inputs settle. An operand is read as `3*hi + lo`, with `x_hi` and `y_hi` as the most significant digits. If any input carries the unused code, all three results are forced to level 0 and an error flag is raised.

Top module: `tern_cmp2`

## Requirements
- R1: A trit is coded as 2'b00 for 0, 2'b01 for 1 and 2'b10 for 2. An operand's value is 3 times its high trit plus its low trit.
- R2: `eq_t` is 2'b10 (level 2) exactly when `x_hi == y_hi` and `x_lo == y_lo`. Otherwise it is 2'b00 (level 0).
- R3: `lt_t` is 2'b10 exactly when the value of X is smaller than the value of Y. Otherwise it is 2'b00.
- R4: `gt_t` is 2'b10 exactly when the value of X is larger than the value of Y. Otherwise it is 2'b00.
- R5: For every pair of legal inputs, exactly one of `eq_t`, `lt_t` and `gt_t` is 2'b10.
- R6: When the high trits differ, the high trits alone decide the result, whatever the low trits are.
- R7: If any input trit is 2'b11, `code_err` is 1 and all three results are 2'b00. Otherwise `code_err` is 0.
- R8: The results only ever take the codes 2'b00 and 2'b10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x_hi | input | 2 | High trit of operand X |
| x_lo | input | 2 | Low trit of operand X |
| y_hi | input | 2 | High trit of operand Y |
| y_lo | input | 2 | Low trit of operand Y |
| eq_t | output | 2 | Ternary result, X equals Y |
| lt_t | output | 2 | Ternary result, X less than Y |
| gt_t | output | 2 | Ternary result, X greater than Y |
| code_err | output | 1 | An input trit carries the unused code |

## Verification
All outputs are due in the same cycle as the stimulus, because no register lies between the inputs and the outputs. The driver applies each input pair just after a rising clock edge and queues the expected results. The monitor takes the matching entry off the queue at the following falling edge, half a period later, once the logic has settled. The 81 legal pairs are compared with integer arithmetic, and cases that contain the unused code are checked for R7.

// File: rtl/tern_cmp2.sv
module tern_cmp2 (
  input  logic [1:0] x_hi,
  input  logic [1:0] x_lo,
  input  logic [1:0] y_hi,
  input  logic [1:0] y_lo,
  output logic [1:0] eq_t,
  output logic [1:0] lt_t,
  output logic [1:0] gt_t,
  output logic       code_err
);
  localparam logic [1:0] T_LO = 2'b00;
  localparam logic [1:0] T_HI = 2'b10;

  function automatic logic [2:0] unary(input logic [1:0] t);
    unary = {t == 2'b10, t == 2'b01, t == 2'b00};
  endfunction

  logic [2:0] xh, xl, yh, yl;
  assign xh = unary(x_hi);
  assign xl = unary(x_lo);
  assign yh = unary(y_hi);
  assign yl = unary(y_lo);

  logic hi_eq, lo_eq, hi_lt, lo_lt, hi_gt, lo_gt;
  assign hi_eq = |(xh & yh);
  assign lo_eq = |(xl & yl);
  assign hi_lt = (xh[0] & (yh[1] | yh[2])) | (xh[1] & yh[2]);
  assign lo_lt = (xl[0] & (yl[1] | yl[2])) | (xl[1] & yl[2]);
  assign hi_gt = (yh[0] & (xh[1] | xh[2])) | (yh[1] & xh[2]);
  assign lo_gt = (yl[0] & (xl[1] | xl[2])) | (yl[1] & xl[2]);

  assign code_err = (&x_hi) | (&x_lo) | (&y_hi) | (&y_lo);

  logic is_eq, is_lt, is_gt;
  assign is_eq = hi_eq & lo_eq;
  assign is_lt = hi_lt | (hi_eq & lo_lt);
  assign is_gt = hi_gt | (hi_eq & lo_gt);

  assign eq_t = (is_eq & ~code_err) ? T_HI : T_LO;
  assign lt_t = (is_lt & ~code_err) ? T_HI : T_LO;
  assign gt_t = (is_gt & ~code_err) ? T_HI : T_LO;
endmodule

// File: rtl/tern_cmp2_chk.sv
module tern_cmp2_chk (
  input logic [1:0] x_hi,
  input logic [1:0] x_lo,
  input logic [1:0] y_hi,
  input logic [1:0] y_lo,
  input logic [1:0] eq_t,
  input logic [1:0] lt_t,
  input logic [1:0] gt_t,
  input logic       code_err
);
  always_comb begin
    a_r8_codes: assert ((eq_t == 2'b00 || eq_t == 2'b10) &&
                        (lt_t == 2'b00 || lt_t == 2'b10) &&
                        (gt_t == 2'b00 || gt_t == 2'b10));
    a_r5_single: assert (code_err ||
      ((eq_t == 2'b10) + (lt_t == 2'b10) + (gt_t == 2'b10)) == 1);
    a_r7_quiet: assert (!code_err || (eq_t == 2'b00 && lt_t == 2'b00 && gt_t == 2'b00));
    a_r2_match: assert (eq_t != 2'b10 || (x_hi == y_hi && x_lo == y_lo));
    a_r6_hi_order: assert (code_err || x_hi == y_hi ||
      (x_hi < y_hi ? lt_t == 2'b10 : gt_t == 2'b10));
  end
endmodule

bind tern_cmp2 tern_cmp2_chk u_chk (.*);

// File: tb/tb_tern_cmp2.sv
module tb_tern_cmp2;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [1:0] x_hi = '0, x_lo = '0, y_hi = '0, y_lo = '0;
  logic [1:0] eq_t, lt_t, gt_t;
  logic       code_err;

  tern_cmp2 dut (.x_hi(x_hi), .x_lo(x_lo), .y_hi(y_hi), .y_lo(y_lo),
                 .eq_t(eq_t), .lt_t(lt_t), .gt_t(gt_t), .code_err(code_err));

  int n_chk = 0, n_bad = 0;
  logic [6:0] exp_q[$];
  string      tag_q[$];
  bit         drv_done = 0;

  task automatic send(input logic [1:0] a1, a0, b1, b0, input string tag);
    logic [6:0] e;
    int va, vb;
    @(posedge clk); #1;
    x_hi = a1; x_lo = a0; y_hi = b1; y_lo = b0;
    if (a1 == 2'b11 || a0 == 2'b11 || b1 == 2'b11 || b0 == 2'b11)
      e = 7'b00_00_00_1;
    else begin
      va = 3 * a1 + a0;
      vb = 3 * b1 + b0;
      e = {(va == vb) ? 2'b10 : 2'b00, (va < vb) ? 2'b10 : 2'b00,
           (va > vb) ? 2'b10 : 2'b00, 1'b0};
    end
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        logic [6:0] e, a;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        a = {eq_t, lt_t, gt_t, code_err};
        n_chk++;
        if (a !== e) begin
          n_bad++;
          $display("FAIL %s: got %b expected %b", t, a, e);
        end
        if (!e[0]) begin
          n_chk++;
          if (((eq_t == 2'b10) + (lt_t == 2'b10) + (gt_t == 2'b10)) != 1 ||
              eq_t[0] || lt_t[0] || gt_t[0]) begin
            n_bad++;
            $display("FAIL R5/R8: got %b expected one level-2 result, %b", a, e);
          end
        end
      end
    end
  end

  initial begin
    #4000000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R1: trit weights, 1*3+1 = 4 beats 0*3+2 = 2
    send(2'b01, 2'b01, 2'b00, 2'b10, "R1");
    send(2'b00, 2'b10, 2'b01, 2'b00, "R1");
    for (int a = 0; a < 9; a++)
      for (int b = 0; b < 9; b++) begin
        string tg;
        if (a / 3 != b / 3 && ((a % 3 < b % 3) != (a / 3 < b / 3)) && a % 3 != b % 3)
          tg = "R6";
        else if (a == b) tg = "R2";
        else if (a < b) tg = "R3";
        else tg = "R4";
        send(2'(a / 3), 2'(a % 3), 2'(b / 3), 2'(b % 3), tg);
      end
    // R7: unused code on each position
    send(2'b11, 2'b00, 2'b00, 2'b00, "R7");
    send(2'b00, 2'b11, 2'b00, 2'b00, "R7");
    send(2'b00, 2'b00, 2'b11, 2'b00, "R7");
    send(2'b01, 2'b10, 2'b01, 2'b11, "R7");
    send(2'b11, 2'b11, 2'b11, 2'b11, "R7");
    send(2'b10, 2'b10, 2'b00, 2'b00, "R4");
    @(posedge clk);
    @(posedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule